// File: doc/BRIEF.md
# Stage Polarity Twist Calibrator

This block is the digital controller that calibrates a chain of cascaded analog amplifier stages at startup. Each stage carries a small output offset of unknown sign. When the offsets of neighbouring stages share a sign, they add up along the chain, and every later stage amplifies them again. The controller measures the sign of each stage's offset. It then chooses, for each reconfigurable link between two stages, whether the link passes the differential pair straight or crossed. The aim is that the accumulated offset alternates in sign from stage to stage.

A start request moves the controller into a test phase. In that phase the two inputs of every stage are tied together and left to settle for a programmable number of cycles. A single one-cycle stimulus pulse then goes into the tied inputs. A fixed number of cycles after that pulse, the controller latches one polarity bit per stage from the external timing comparators. During a one-cycle reconfiguration phase it turns those bits into twist controls and applies them. It then raises a completion flag and waits for the next start.

Only the links selected by a parameter mask can be reconfigured. The mask normally selects the earliest links, because the offset of an early stage is multiplied by the gain of every stage behind it. Links outside the mask are always driven straight.

Top module: `twist_cal_top`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, short_o, stim_o, reconf_o, done_o and every bit of twist_o are 0.
- R2: A start_i sampled high while the block is idle or done moves it to the test phase. In the next cycle short_o is 1 and done_o is 0.
- R3: short_o stays 1 for settle_i+1 cycles before the stimulus (settle_i is sampled with the start), during the stimulus cycle, and through the sampling window.
- R4: Each calibration produces exactly one stim_o pulse, one cycle long, and only while short_o is 1.
- R5: polarity_i is captured at the clock edge that ends the SAMPLE_DLY-th cycle after the stimulus cycle. Values present on polarity_i in any other cycle have no effect.
- R6: For a reconfigurable link k (bit k of twist_o, between stage k and stage k+1, where bit s of polarity_i belongs to stage s), twist_o[k] becomes 1 (crossed) when the captured bits of the two stages are equal, and 0 (straight) when they differ.
- R7: A link whose bit in LINK_MASK is 0 always has twist_o bit 0.
- R8: twist_o keeps its previous value until the reconfiguration cycle ends. The new value appears in the first cycle in which done_o is 1.
- R9: reconf_o is 1 for exactly one cycle, right after the sampling window. In that cycle short_o is 0.
- R10: done_o becomes 1 after the reconfiguration cycle and stays 1 until the next accepted start.
- R11: A start_i raised while a calibration is in progress is ignored. The calibration keeps its timing and produces no extra stimulus.
- R12: A new start after completion runs a complete new calibration, and twist_o is replaced by the result of the new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request, sampled on each rising edge |
| settle_i | input | SETTLE_W | Extra settle cycles in the test phase, latched with the start |
| polarity_i | input | NUM_STAGES | Comparator result per stage, bit s for stage s |
| short_o | output | 1 | Ties the inputs of every stage together (test phase) |
| stim_o | output | 1 | One-cycle digital test pulse into the tied inputs |
| reconf_o | output | 1 | Reconfiguration phase indicator |
| twist_o | output | NUM_STAGES-1 | Per-link control, 1 crossed, 0 straight |
| done_o | output | 1 | Calibration complete |

## Verification
The hardest case to reach from the ports is showing that the polarity bits are latched at exactly one edge. A capture one cycle early or late would still yield a plausible twist pattern. The bench therefore drives the intended polarity word only in the single cycle that its own timing model marks as the capture cycle. In every other cycle it drives that word with stage 0 inverted, which changes the result for link 0. Any shift in the capture instant then shows up as a wrong twist_o value. A start pulse injected in the middle of a run shows that a busy request is ignored: the stimulus count stays at one and the completion time is unchanged.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHORT  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_APPLY  = 3'd4,
        ST_DONE   = 3'd5
    } twc_state_e;

    function automatic logic in_test_phase(input twc_state_e s);
        return (s == ST_SHORT) || (s == ST_PULSE) || (s == ST_SAMPLE);
    endfunction

endpackage

// File: rtl/twc_sequencer.sv
module twc_sequencer
    import twc_pkg::*;
#(
    parameter int SETTLE_W   = 8,
    parameter int SAMPLE_DLY = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output twc_state_e          state_o,
    output logic                capture_o,
    output logic                apply_o
);
    localparam int DLY_W = $clog2(SAMPLE_DLY + 1);
    localparam int CNT_W = (SETTLE_W > DLY_W) ? SETTLE_W : DLY_W;
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_DLY - 1);

    typedef struct packed {
        twc_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [SETTLE_W-1:0] settle;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] settle_ext;

    assign settle_ext = CNT_W'(r_q.settle);

    always_comb begin
        r_d       = r_q;
        capture_o = 1'b0;
        apply_o   = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state  = ST_SHORT;
                    r_d.cnt    = '0;
                    r_d.settle = settle_i;
                end
            end
            ST_SHORT: begin
                if (r_q.cnt == settle_ext) begin
                    r_d.state = ST_PULSE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                r_d.state = ST_SAMPLE;
                r_d.cnt   = '0;
            end
            ST_SAMPLE: begin
                if (r_q.cnt == SMP_LAST) begin
                    capture_o = 1'b1;
                    r_d.state = ST_APPLY;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_APPLY: begin
                apply_o   = 1'b1;
                r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.settle <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/twc_pol_store.sv
module twc_pol_store #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_i,
    input  logic [NUM_STAGES-1:0] pol_i,
    output logic [NUM_STAGES-1:0] pol_o
);
    logic [NUM_STAGES-1:0] pol_d, pol_q;

    always_comb begin
        pol_d = pol_q;
        if (capture_i) pol_d = pol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    assign pol_o = pol_q;

endmodule

// File: rtl/twc_link_map.sv
module twc_link_map #(
    parameter int                    NUM_STAGES = 4,
    parameter logic [NUM_STAGES-2:0] LINK_MASK  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  apply_i,
    input  logic [NUM_STAGES-1:0] pol_i,
    output logic [NUM_STAGES-2:0] twist_o
);
    localparam int NUM_LINKS = NUM_STAGES - 1;

    for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
        if (LINK_MASK[k]) begin : g_reconf
            logic tw_d, tw_q;

            always_comb begin
                tw_d = tw_q;
                if (apply_i) tw_d = pol_i[k] ~^ pol_i[k+1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tw_q <= 1'b0;
                else        tw_q <= tw_d;
            end

            assign twist_o[k] = tw_q;
        end else begin : g_fixed
            assign twist_o[k] = 1'b0;
        end
    end

endmodule

// File: rtl/twist_cal_top.sv
module twist_cal_top
    import twc_pkg::*;
#(
    parameter int                    NUM_STAGES = 4,
    parameter int                    SETTLE_W   = 8,
    parameter int                    SAMPLE_DLY = 2,
    parameter logic [NUM_STAGES-2:0] LINK_MASK  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [SETTLE_W-1:0]   settle_i,
    input  logic [NUM_STAGES-1:0] polarity_i,
    output logic                  short_o,
    output logic                  stim_o,
    output logic                  reconf_o,
    output logic [NUM_STAGES-2:0] twist_o,
    output logic                  done_o
);
    twc_state_e            state;
    logic                  capture;
    logic                  apply;
    logic [NUM_STAGES-1:0] pol_held;

    twc_sequencer #(
        .SETTLE_W  (SETTLE_W),
        .SAMPLE_DLY(SAMPLE_DLY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .settle_i (settle_i),
        .state_o  (state),
        .capture_o(capture),
        .apply_o  (apply)
    );

    twc_pol_store #(
        .NUM_STAGES(NUM_STAGES)
    ) u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(capture),
        .pol_i    (polarity_i),
        .pol_o    (pol_held)
    );

    twc_link_map #(
        .NUM_STAGES(NUM_STAGES),
        .LINK_MASK (LINK_MASK)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply_i(apply),
        .pol_i  (pol_held),
        .twist_o(twist_o)
    );

    assign short_o  = in_test_phase(state);
    assign stim_o   = (state == ST_PULSE);
    assign reconf_o = (state == ST_APPLY);
    assign done_o   = (state == ST_DONE);

endmodule

// File: rtl/twc_checks.sv
module twc_checks #(
    parameter int                    NUM_STAGES = 4,
    parameter logic [NUM_STAGES-2:0] LINK_MASK  = '1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  short_o,
    input logic                  stim_o,
    input logic                  reconf_o,
    input logic [NUM_STAGES-2:0] twist_o,
    input logic                  done_o
);
    AST_START_ENTERS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (short_o && !done_o)); // R2

    AST_STIM_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        stim_o |-> short_o); // R3

    AST_STIM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stim_o |=> !stim_o); // R4

    AST_UNMASKED_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ((twist_o & ~LINK_MASK) == '0)); // R7

    AST_TWIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reconf_o |=> $stable(twist_o)); // R8

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({short_o, reconf_o, done_o})); // R9

    AST_RECONF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_o |=> (done_o && !reconf_o)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R10

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (short_o && !stim_o && start_i) |=> !done_o); // R11

endmodule

bind twist_cal_top twc_checks #(
    .NUM_STAGES(NUM_STAGES),
    .LINK_MASK (LINK_MASK)
) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .short_o (short_o),
    .stim_o  (stim_o),
    .reconf_o(reconf_o),
    .twist_o (twist_o),
    .done_o  (done_o)
);

// File: tb/twist_cal_top_test.sv
module twist_cal_top_test;
    localparam int   CLK_PERIOD = 10;
    localparam int   N          = 4;
    localparam int   SW         = 8;
    localparam int   SMP        = 2;
    localparam logic [N-2:0] MASK = 3'b011;
    localparam int   WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic [N-1:0]  polarity_i = '0;
    logic          short_o, stim_o, reconf_o, done_o;
    logic [N-2:0]  twist_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural model
    int           m_phase = 0;   // 0 idle 1 short 2 pulse 3 sample 4 apply 5 done
    int           m_cnt = 0;
    int           m_settle = 0;
    logic [N-1:0] m_pol = '0;
    logic [N-2:0] m_twist = '0;
    logic [N-1:0] good_pol = '0;

    twist_cal_top #(
        .NUM_STAGES(N), .SETTLE_W(SW), .SAMPLE_DLY(SMP), .LINK_MASK(MASK)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
        .polarity_i(polarity_i), .short_o(short_o), .stim_o(stim_o),
        .reconf_o(reconf_o), .twist_o(twist_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_settle = 0; m_pol = '0; m_twist = '0;
        end else begin
            case (m_phase)
                0, 5: if (start_i) begin m_phase = 1; m_cnt = 0; m_settle = int'(settle_i); end
                1: if (m_cnt == m_settle) m_phase = 2; else m_cnt++;
                2: begin m_phase = 3; m_cnt = 0; end
                3: if (m_cnt == SMP - 1) begin m_pol = polarity_i; m_phase = 4; end else m_cnt++;
                4: begin
                    for (int k = 0; k < N - 1; k++)
                        m_twist[k] = MASK[k] && (m_pol[k] == m_pol[k+1]);
                    m_phase = 5;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // drive the wanted word only in the capture cycle (R5)
    always @(negedge clk)
        polarity_i <= (m_phase == 3 && m_cnt == SMP - 1) ? good_pol : (good_pol ^ 4'b0001);

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 short_o",  short_o,  (m_phase >= 1 && m_phase <= 3));
            check("R4 stim_o",   stim_o,   (m_phase == 2));
            check("R9 reconf_o", reconf_o, (m_phase == 4));
            check("R10 done_o",  done_o,   (m_phase == 5));
            check("R6 twist_o",  twist_o,  m_twist);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_cal(input int settle, input logic [N-1:0] pol,
                           input logic [N-2:0] exp_tw, input bit poke, input string tag);
        int stims = 0;
        int len = 0;
        logic [N-2:0] prev_tw;
        prev_tw = twist_o;
        @(negedge clk);
        settle_i = SW'(settle); good_pol = pol; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({"R2 enter test ", tag}, {short_o, done_o}, 2'b10);
        while (!done_o && len < 1000) begin
            check({"R8 twist held ", tag}, twist_o, prev_tw);
            if (stim_o) stims++;
            start_i = (poke && short_o && len == 0);
            len++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check({"R4 one pulse ", tag}, stims, 1);
        check({"R11 run length ", tag}, len, settle + 1 + 1 + SMP + 1);
        check({"R6 R7 twist result ", tag}, twist_o, exp_tw);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {short_o, stim_o, reconf_o, done_o, twist_o}, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {short_o, stim_o, reconf_o, done_o, twist_o}, '0);

        run_cal(2, 4'b0000, 3'b011, 0, "all equal");
        repeat (10) @(negedge clk);
        check("R10 done held", done_o, 1'b1);
        check("R8 twist kept idle", twist_o, 3'b011);

        run_cal(0, 4'b0101, 3'b000, 1, "alternating busy start");
        run_cal(5, 4'b0011, 3'b001, 0, "masked link equal");
        run_cal(1, 4'b1110, 3'b010, 1, "middle equal");
        run_cal(3, 4'b1111, 3'b011, 0, "R12 rerun");
        check("R7 link2 straight", twist_o[2], 1'b0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule